// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a synchronous host read and write one external asynchronous static RAM of 2^19 sixteen-bit words. Each word has two byte lanes. The host offers one request at a time on a valid/ready port. A request carries a write flag, an address, write data and a two-bit lane mask. When the access ends, the controller returns a one-cycle response pulse. For reads, the pulse comes with the captured data. The controller produces every memory strobe from a clock-cycle timer. The timing windows are parameters: read wait, turnaround before a write, and write pulse width. Each one is the nanosecond requirement of the RAM divided by the clock period and rounded up.

On the memory side the controller drives the following:
- one active-low chip enable and one active-high chip enable, which are always asserted together;
- a write strobe and a read-output strobe, both active low;
- one active-low select for each byte lane;
- the data bus as three signals: a separate output, output enable and input.

The controller never drives the data bus while the RAM could be driving it. The output strobe is held inactive for the turnaround count before the write strobe falls. The data driver turns on only while the write strobe is low, and it turns off on the same clock edge that raises the write strobe. The address is registered when a request is accepted. It holds until the next request is accepted, so it never changes while the write strobe is low.

Back-pressure rules on the host side:
- `req_ready` is high only in the idle state.
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- While `req_ready` is low, `req_valid` and the request fields are ignored.
- `rsp_valid` cannot be stalled. The host must take it in the cycle it appears.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs hold the following values: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lb_n`=1, `mem_ub_n`=1, `mem_dq_oe`=0, `rsp_valid`=0. This reset is asynchronous and also applies in the middle of an operation.
- R2: `req_ready` is 1 only in the idle state. A request presented while `req_ready`=0 has no effect on the memory contents.
- R3: While the RAM is selected, `mem_ce_n`=0 and `mem_ce`=1 together. Either strobe being low implies the RAM is selected.
- R4: A read holds `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles. It captures `mem_dq_in` on the last of those cycles and presents it on `rsp_rdata`.
- R5: `req_be[0]`=1 drives `mem_lb_n` low, which selects data bits 7:0. `req_be[1]`=1 drives `mem_ub_n` low, which selects bits 15:8. Lane selects are active only during the access phases. A mask of 00 keeps both selects high for the whole operation.
- R6: A write first holds `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0 for exactly TURN_CYC cycles, with the RAM selected.
- R7: After the turnaround, `mem_we_n`=0 for exactly WE_CYC cycles. `mem_dq_oe`=1 in exactly those cycles, and `mem_dq_out` equals the write data.
- R8: `mem_addr` equals the accepted address for the whole operation. `mem_addr` changes only while `mem_we_n`=1.
- R9: Each operation gives one `rsp_valid` pulse in a single gap cycle. In that cycle the RAM stays selected, both strobes are high and the lanes are off. The pulse arrives RD_CYC+1 cycles after accept for a read, and TURN_CYC+WE_CYC+1 cycles after accept for a write. The next cycle is idle and deselected.
- R10: `mem_oe_n` and `mem_we_n` are never low together. `mem_dq_oe`=1 only while `mem_we_n`=0 and `mem_oe_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data captured by the last read |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned from the RAM |

## Verification
The assertions assume three things:
- RD_CYC, WE_CYC and TURN_CYC are each at least one.
- The only way to abort an operation is `rst_n`.
- The checker's run-length counters start from a deselected idle cycle, which the controller always passes through between operations.

The stimulus respects these assumptions. It drives the host inputs only on falling clock edges and offers a new request only when `req_ready` is seen high. Its RAM model answers reads combinationally from selected lanes. It stores a lane only while the RAM is selected, the write strobe is low and the controller is driving. Busy-time requests and a reset during the write pulse are applied deliberately, to exercise R2 and R1.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_PULSE = 3'd3,
    ST_GAP   = 3'd4
  } ctrl_state_e;
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int WE_CYC   = 4,
  parameter int TURN_CYC = 3,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          expired,
  output ctrl_state_e   state,
  output logic          accept,
  output logic          capture,
  output logic          finish,
  output logic          load,
  output logic [CW-1:0] load_val
);
  localparam logic [CW-1:0] RD_LOAD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WE_LOAD   = CW'(WE_CYC - 1);
  localparam logic [CW-1:0] TURN_LOAD = CW'(TURN_CYC - 1);

  ctrl_state_e state_q, state_d;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_READ) && expired;
  assign finish  = capture || ((state_q == ST_PULSE) && expired);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        load = 1'b1;
        if (req_write) begin
          state_d  = ST_TURN;
          load_val = TURN_LOAD;
        end else begin
          state_d  = ST_READ;
          load_val = RD_LOAD;
        end
      end
      ST_READ:  if (expired) state_d = ST_GAP;
      ST_TURN:  if (expired) begin
        state_d  = ST_PULSE;
        load     = 1'b1;
        load_val = WE_LOAD;
      end
      ST_PULSE: if (expired) state_d = ST_GAP;
      ST_GAP:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              finish,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rsp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= finish;
      if (capture) rdata_q <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int RD_CYC   = 6,
  parameter int WE_CYC   = 4,
  parameter int TURN_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int LANES = 2;
  localparam int MAX_A = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int MAXC  = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC);

  ctrl_state_e       state;
  logic              accept, capture, finish, load, expired;
  logic [CW-1:0]     load_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  lane_n;
  logic              sel_on, lanes_on;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .expired(expired)
  );

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .expired(expired), .state(state), .accept(accept), .capture(capture),
    .finish(finish), .load(load), .load_val(load_val)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .finish(finish), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .mem_dq_in(mem_dq_in), .addr_q(addr_q),
    .wdata_q(wdata_q), .be_q(be_q), .rdata_q(rsp_rdata), .rsp_q(rsp_valid)
  );

  // Moore decode of the strobes from the registered state
  assign sel_on   = (state != ST_IDLE);
  assign lanes_on = (state == ST_READ) || (state == ST_TURN) || (state == ST_PULSE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = !(lanes_on && be_q[g]);
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !sel_on;
  assign mem_ce     = sel_on;
  assign mem_oe_n   = (state != ST_READ);
  assign mem_we_n   = (state != ST_PULSE);
  assign mem_dq_oe  = (state == ST_PULSE);
  assign mem_dq_out = wdata_q;
  assign mem_lb_n   = lane_n[0];
  assign mem_ub_n   = lane_n[LANES-1];
endmodule

// File: rtl/sram_ctrl_checks.sv
module sram_ctrl_checks #(
  parameter int ADDR_W   = 19,
  parameter int RD_CYC   = 6,
  parameter int WE_CYC   = 4,
  parameter int TURN_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);
  logic [15:0] hi_run, we_run, oe_run;

  // run lengths: selected-with-both-strobes-high, write strobe low, output strobe low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      we_run <= '0;
      oe_run <= '0;
    end else begin
      hi_run <= (!mem_ce_n && mem_we_n && mem_oe_n) ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      we_run <= (!mem_we_n) ? ((we_run == 16'hFFFF) ? we_run : we_run + 1'b1) : '0;
      oe_run <= (!mem_oe_n) ? ((oe_run == 16'hFFFF) ? oe_run : oe_run + 1'b1) : '0;
    end
  end

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r10_driver_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));
  a_r3_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (!mem_ce_n && mem_ce));
  a_r8_addr_steady_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  a_r8_addr_moves_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> mem_we_n);
  a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_rsp_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !req_ready));
  a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (hi_run == 16'(TURN_CYC)));
  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 16'(WE_CYC)));
  a_r4_read_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == 16'(RD_CYC)));
  a_r5_lanes_need_select: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lb_n && mem_ub_n));
endmodule

bind sram_ctrl sram_ctrl_checks #(
  .ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC)
) u_checks (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  localparam int RD = 6;
  localparam int WE = 4;
  localparam int TU = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  sram_ctrl #(.RD_CYC(RD), .WE_CYC(WE), .TURN_CYC(TU)) u_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // RAM model: 256 words indexed by the low address bits
  logic [15:0] model [256];
  logic        sel;
  assign sel = !mem_ce_n && mem_ce;
  initial for (int i = 0; i < 256; i++) model[i] = '0;

  always @(posedge clk) begin
    if (sel && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) model[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  assign mem_dq_in = (sel && !mem_oe_n && mem_we_n) ?
      {(mem_ub_n ? 8'h00 : model[mem_addr[7:0]][15:8]),
       (mem_lb_n ? 8'h00 : model[mem_addr[7:0]][7:0])} : 16'h0000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  // Vector: {write, be[1:0], addr[18:0], wdata[15:0], expected read[15:0]}
  function automatic logic [53:0] mk(input logic w, input logic [1:0] b,
                                     input logic [18:0] a, input logic [15:0] d,
                                     input logic [15:0] e);
    return {w, b, a, d, e};
  endfunction

  localparam logic [53:0] VEC [0:8] = '{
    mk(1'b1, 2'b11, 19'h00010, 16'hA5C3, 16'h0000),
    mk(1'b0, 2'b11, 19'h00010, 16'h0000, 16'hA5C3),
    mk(1'b1, 2'b01, 19'h00010, 16'h1177, 16'h0000),
    mk(1'b0, 2'b11, 19'h00010, 16'h0000, 16'hA577),
    mk(1'b1, 2'b10, 19'h7FFFF, 16'hBEEF, 16'h0000),
    mk(1'b0, 2'b11, 19'h7FFFF, 16'h0000, 16'hBE00),
    mk(1'b1, 2'b00, 19'h00010, 16'hFFFF, 16'h0000),
    mk(1'b0, 2'b11, 19'h00010, 16'h0000, 16'hA577),
    mk(1'b0, 2'b10, 19'h00010, 16'h0000, 16'hA577)
  };

  task automatic run_op(input logic wr, input logic [1:0] be, input logic [18:0] addr,
                        input logic [15:0] wd, input logic [15:0] exp, input bit hold);
    int n = 1;
    int oe_lo = 0, we_lo = 0, pre = 0, drv = 0;
    int bad_drv = 0, bad_addr = 0, bad_lane = 0, bad_sel = 0, rdy = 0;
    logic [15:0] mask;
    mask = {{8{be[1]}}, {8{be[0]}}};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    if (hold) begin
      // busy-time request that must not be taken (R2)
      req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00010;
      req_wdata = 16'h0000; req_be = 2'b11;
    end
    while (!rsp_valid && n < 200) begin
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) we_lo++; else if (we_lo == 0) pre++;
      if (mem_dq_oe) begin
        drv++;
        if (mem_dq_out != wd) bad_drv++;
      end
      if (mem_addr != addr) bad_addr++;
      if (mem_lb_n != !be[0] || mem_ub_n != !be[1]) bad_lane++;
      if (mem_ce_n || !mem_ce) bad_sel++;
      if (req_ready) rdy++;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(n == (wr ? TU + WE + 1 : RD + 1), "R9 response latency", n, wr ? TU + WE + 1 : RD + 1);
    if (wr) begin
      chk(pre == TU, "R6 turnaround cycles", pre, TU);
      chk(oe_lo == 0, "R6 output strobe in write", oe_lo, 0);
      chk(we_lo == WE, "R7 write pulse cycles", we_lo, WE);
      chk(drv == WE && bad_drv == 0, "R7 driver window and data", drv, WE);
    end else begin
      chk(oe_lo == RD && we_lo == 0, "R4 read strobe cycles", oe_lo, RD);
      chk((rsp_rdata & mask) == (exp & mask), "R4 read data", rsp_rdata & mask, exp & mask);
    end
    chk(bad_addr == 0, "R8 address held", bad_addr, 0);
    chk(bad_lane == 0, "R5 lane selects", bad_lane, 0);
    chk(bad_sel == 0, "R3 dual enable", bad_sel, 0);
    chk(rdy == 0, "R2 ready low while busy", rdy, 0);
    chk(!mem_ce_n && mem_ce && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n &&
        !mem_dq_oe && mem_addr == addr, "R9 gap cycle state",
        {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 7'b0111110);
    @(negedge clk);
    chk(!rsp_valid && req_ready && mem_ce_n && !mem_ce, "R9 idle after response",
        {rsp_valid, req_ready, mem_ce_n, mem_ce}, 4'b0110);
  endtask

  task automatic chk_quiet(input string req);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n &&
        !mem_dq_oe && !rsp_valid, req,
        {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid},
        8'b10111100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_quiet("R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);

    for (int i = 0; i < 9; i++) begin
      run_op(VEC[i][53], VEC[i][52:51], VEC[i][50:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
    end

    // R2: write to 0x20 while a busy-time write to 0x10 is offered
    run_op(1'b1, 2'b11, 19'h00020, 16'h1234, 16'h0000, 1'b1);
    run_op(1'b0, 2'b11, 19'h00010, 16'h0000, 16'hA577, 1'b0);
    run_op(1'b0, 2'b11, 19'h00020, 16'h0000, 16'h1234, 1'b0);

    // R1: asynchronous reset during the write pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00030;
    req_wdata = 16'h5A5A; req_be = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 20 && !mem_dq_oe; k++) @(negedge clk);
    chk(mem_dq_oe == 1'b1, "R7 pulse reached before reset", mem_dq_oe, 1);
    rst_n = 1'b0;
    #1;
    chk_quiet("R1 reset mid-write");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_ce_n, "R1 idle after mid-write reset", {req_ready, mem_ce_n}, 2'b11);
    run_op(1'b0, 2'b01, 19'h7FFFF, 16'h0000, 16'h0000, 1'b0);

    finish_run();
  end
endmodule